// File: doc/BRIEF.md
# JTAG-Driven SPI Flash Pass-Through

This block lets a host that only has a JTAG cable read, erase and program a serial configuration flash wired to the device. It contains a complete test access port controller, a six-bit instruction register and a small data-register section. The data-register section holds a device identification register, a one-bit bypass register and a one-bit flash window.

When the instruction register holds the flash-window code and the controller is in Shift-DR, the JTAG lines are joined to the SPI lines. TCK becomes the serial clock, TDI becomes MOSI and MISO drives TDO, and the flash chip select is held active. Each visit to Shift-DR is therefore exactly one SPI transaction, framed by chip select. No data is buffered anywhere on that path. The host builds the flash commands itself, and the block adds no sequencing of its own.

Top module: `jspi_bridge`

## Requirements
- R1: The controller follows the sixteen-state JTAG state diagram and advances on rising TCK under TMS. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. A low level on `trst_n` forces Test-Logic-Reset at once.
- R2: The instruction register is 6 bits wide and is shifted least significant bit first. It loads the pattern 6'b000001 in Capture-IR. The active instruction changes only at Update-IR, and Test-Logic-Reset sets it to the identification code 6'h09.
- R3: With code 6'h09 active, Capture-DR loads the 32-bit identification value (default 32'h4A7C31E5), which then shifts out least significant bit first.
- R4: Every code except 6'h02 and 6'h09 selects a one-bit bypass register. That register captures 0 and delays TDI by one TCK cycle (6'h3F is among these codes).
- R5: `spi_cs_n` is low only while the active code is 6'h02 and the controller is in Shift-DR. It is updated on falling TCK, so it falls on the falling edge after Shift-DR is entered and rises on the falling edge after Shift-DR is left. This holds through Pause-DR as well.
- R6: `spi_sclk` equals TCK while chip select is low and is held low at all other times. The flash therefore sees one rising clock edge for each TCK rising edge spent in Shift-DR.
- R7: `spi_mosi` equals TDI while chip select is low and is held low otherwise.
- R8: While chip select is low, TDO follows `spi_miso` with no register in between. The 1-bit flash window adds no delay of its own.
- R9: `tdo_oe` is high only after a falling TCK edge in Shift-IR or Shift-DR. Outside those states TDO and `tdo_oe` are low, and both are updated on falling TCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock, also the source of the SPI clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out |
| tdo_oe | output | 1 | Output enable for the TDO pad driver |
| spi_sclk | output | 1 | Gated serial clock to the flash |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |

## Verification
The controller state and the captured register values change on a rising TCK edge. TDO, `tdo_oe` and chip select follow on the next falling edge, so the bench samples one nanosecond after every falling edge. That sample holds the bit the host would take at the next rising edge: bit *i* of a shift is read after the *i*-th clock in Shift-DR or Shift-IR. The SPI clock, chip select and MOSI are also sampled one nanosecond after each rising edge, while TCK is high, to show that the flash clock pulses in that clock's cycle and in no other. A model flash in the bench takes MOSI on rising `spi_sclk` and presents MISO after the falling edge. It counts its clock edges, so the number of bits transferred is checked directly at the SPI pins.

// File: rtl/jspi_pkg.sv
package jspi_pkg;

    typedef enum logic [3:0] {
        ST_EX2_DR = 4'h0,
        ST_EX1_DR = 4'h1,
        ST_SH_DR  = 4'h2,
        ST_PAU_DR = 4'h3,
        ST_SEL_IR = 4'h4,
        ST_UPD_DR = 4'h5,
        ST_CAP_DR = 4'h6,
        ST_SEL_DR = 4'h7,
        ST_EX2_IR = 4'h8,
        ST_EX1_IR = 4'h9,
        ST_SH_IR  = 4'hA,
        ST_PAU_IR = 4'hB,
        ST_RTI    = 4'hC,
        ST_UPD_IR = 4'hD,
        ST_CAP_IR = 4'hE,
        ST_TLR    = 4'hF
    } tap_state_e;

    // Next controller state for a given TMS level.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic logic is_shift(input tap_state_e s);
        return (s == ST_SH_DR) || (s == ST_SH_IR);
    endfunction

endpackage

// File: rtl/jspi_tap_ctrl.sv
module jspi_tap_ctrl
    import jspi_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e state;
    } tap_regs_t;

    tap_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.state = tap_next(r_q.state, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{state: ST_TLR};
        else         r_q <= r_d;
    end

    assign state_o = r_q.state;

    // Run length of TMS-high edges, saturating at five (assertion support).
    logic [2:0] tms_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                tms_run_q <= 3'd0;
        else if (!tms)              tms_run_q <= 3'd0;
        else if (tms_run_q != 3'd5) tms_run_q <= tms_run_q + 3'd1;
    end

    p_tlr_after_five_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run_q == 3'd5) |-> (r_q.state == ST_TLR));

endmodule

// File: rtl/jspi_ir_reg.sv
module jspi_ir_reg
    import jspi_pkg::*;
#(
    parameter int                    IR_WIDTH   = 6,
    parameter logic [IR_WIDTH-1:0]   IR_CAPTURE = 6'b000001,
    parameter logic [IR_WIDTH-1:0]   IR_DEFAULT = 6'h09
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tdi,
    input  tap_state_e          state_i,
    output logic [IR_WIDTH-1:0] ir_o,
    output logic                ir_bit_o
);

    typedef struct packed {
        logic [IR_WIDTH-1:0] sr;
        logic [IR_WIDTH-1:0] ir;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state_i)
            ST_CAP_IR: r_d.sr = IR_CAPTURE;
            ST_SH_IR:  r_d.sr = {tdi, r_q.sr[IR_WIDTH-1:1]};
            ST_UPD_IR: r_d.ir = r_q.sr;
            ST_TLR:    r_d.ir = IR_DEFAULT;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sr: IR_CAPTURE, ir: IR_DEFAULT};
        else         r_q <= r_d;
    end

    assign ir_o     = r_q.ir;
    assign ir_bit_o = r_q.sr[0];

    p_ir_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(r_q.ir));

    p_ir_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_IR) |=> (r_q.sr == IR_CAPTURE));

endmodule

// File: rtl/jspi_dr_path.sv
module jspi_dr_path
    import jspi_pkg::*;
#(
    parameter int                      IR_WIDTH     = 6,
    parameter logic [IR_WIDTH-1:0]     WINDOW_CODE  = 6'h02,
    parameter logic [IR_WIDTH-1:0]     ID_CODE      = 6'h09,
    parameter int                      ID_WIDTH     = 32,
    parameter logic [ID_WIDTH-1:0]     ID_VALUE     = 32'h4A7C31E5
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tdi,
    input  tap_state_e          state_i,
    input  logic [IR_WIDTH-1:0] ir_i,
    output logic                window_sel_o,
    output logic                dr_bit_o
);

    typedef struct packed {
        logic [ID_WIDTH-1:0] id_sr;
        logic                byp;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic     id_sel;

    assign window_sel_o = (ir_i == WINDOW_CODE);
    assign id_sel       = (ir_i == ID_CODE);

    always_comb begin
        r_d = r_q;
        if (state_i == ST_CAP_DR) begin
            r_d.byp = 1'b0;
            if (id_sel) r_d.id_sr = ID_VALUE;
        end else if (state_i == ST_SH_DR) begin
            r_d.byp = tdi;
            if (id_sel) r_d.id_sr = {tdi, r_q.id_sr[ID_WIDTH-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{id_sr: ID_VALUE, byp: 1'b0};
        else         r_q <= r_d;
    end

    // The window register never drives TDO here: the pin mux passes MISO instead.
    assign dr_bit_o = id_sel ? r_q.id_sr[0] : r_q.byp;

    p_id_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && id_sel) |=> (r_q.id_sr == ID_VALUE));

    p_bypass_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR) |=> (r_q.byp == 1'b0));

endmodule

// File: rtl/jspi_pin_mux.sv
module jspi_pin_mux
    import jspi_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state_i,
    input  logic       window_sel_i,
    input  logic       ir_bit_i,
    input  logic       dr_bit_i,
    input  logic       tdi_i,
    input  logic       miso_i,
    output logic       tdo_o,
    output logic       tdo_oe_o,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       cs_n_o
);

    typedef struct packed {
        logic cs_n;
        logic tdo;
        logic oe;
    } pin_regs_t;

    pin_regs_t r_d, r_q;
    logic      link_on;

    always_comb begin
        r_d      = r_q;
        r_d.cs_n = !(window_sel_i && (state_i == ST_SH_DR));
        r_d.oe   = is_shift(state_i);
        if (state_i == ST_SH_IR)      r_d.tdo = ir_bit_i;
        else if (state_i == ST_SH_DR) r_d.tdo = dr_bit_i;
        else                          r_d.tdo = 1'b0;
    end

    // Falling-edge registers: chip select settles while TCK is low.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{cs_n: 1'b1, tdo: 1'b0, oe: 1'b0};
        else         r_q <= r_d;
    end

    assign link_on  = !r_q.cs_n;
    assign sclk_o   = tck & link_on;
    assign mosi_o   = tdi_i & link_on;
    assign tdo_o    = link_on ? miso_i : r_q.tdo;
    assign tdo_oe_o = r_q.oe;
    assign cs_n_o   = r_q.cs_n;

    p_oe_shift_only_r9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe_o |-> is_shift(state_i));

    p_cs_framed_r5: assert property (@(posedge tck) disable iff (!trst_n)
        !cs_n_o |-> (window_sel_i && state_i == ST_SH_DR));

endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge
    import jspi_pkg::*;
#(
    parameter int                    IR_WIDTH    = 6,
    parameter logic [IR_WIDTH-1:0]   WINDOW_CODE = 6'h02,
    parameter logic [IR_WIDTH-1:0]   ID_CODE     = 6'h09,
    parameter logic [IR_WIDTH-1:0]   IR_CAPTURE  = 6'b000001,
    parameter int                    ID_WIDTH    = 32,
    parameter logic [ID_WIDTH-1:0]   ID_VALUE    = 32'h4A7C31E5
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic spi_sclk,
    output logic spi_mosi,
    input  logic spi_miso,
    output logic spi_cs_n
);

    tap_state_e          state;
    logic [IR_WIDTH-1:0] ir_q;
    logic                ir_bit;
    logic                dr_bit;
    logic                window_sel;

    jspi_tap_ctrl u_tap (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    jspi_ir_reg #(
        .IR_WIDTH   (IR_WIDTH),
        .IR_CAPTURE (IR_CAPTURE),
        .IR_DEFAULT (ID_CODE)
    ) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state_i  (state),
        .ir_o     (ir_q),
        .ir_bit_o (ir_bit)
    );

    jspi_dr_path #(
        .IR_WIDTH    (IR_WIDTH),
        .WINDOW_CODE (WINDOW_CODE),
        .ID_CODE     (ID_CODE),
        .ID_WIDTH    (ID_WIDTH),
        .ID_VALUE    (ID_VALUE)
    ) u_dr (
        .tck          (tck),
        .trst_n       (trst_n),
        .tdi          (tdi),
        .state_i      (state),
        .ir_i         (ir_q),
        .window_sel_o (window_sel),
        .dr_bit_o     (dr_bit)
    );

    jspi_pin_mux u_pins (
        .tck          (tck),
        .trst_n       (trst_n),
        .state_i      (state),
        .window_sel_i (window_sel),
        .ir_bit_i     (ir_bit),
        .dr_bit_i     (dr_bit),
        .tdi_i        (tdi),
        .miso_i       (spi_miso),
        .tdo_o        (tdo),
        .tdo_oe_o     (tdo_oe),
        .sclk_o       (spi_sclk),
        .mosi_o       (spi_mosi),
        .cs_n_o       (spi_cs_n)
    );

    p_select_needs_code_r5: assert property (@(posedge tck) disable iff (!trst_n)
        !spi_cs_n |-> (ir_q == WINDOW_CODE));

endmodule

// File: tb/jspi_bridge_bench.sv
module jspi_bridge_bench;

    localparam logic [5:0]  WIN = 6'h02;
    localparam logic [5:0]  IDC = 6'h09;
    localparam logic [31:0] IDV = 32'h4A7C31E5;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    always #4 tck = ~tck;

    jspi_bridge u_jspi_bridge (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Model flash: takes MOSI on rising SCLK, advances MISO on falling SCLK.
    logic [63:0] fl_tx = 64'hC3A5_0F96_7E18_B24D;
    logic [63:0] fl_rx = 64'h0;
    int          fl_cnt = 0;
    int          fl_ptr = 0;
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        fl_rx[fl_cnt % 64] = spi_mosi;
        fl_cnt = fl_cnt + 1;
    end
    always @(negedge spi_sclk) fl_ptr = fl_cnt;
    assign spi_miso = fl_tx[fl_ptr % 64];

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic hi_cs, hi_sclk, hi_mosi;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); #1;
        hi_cs = spi_cs_n; hi_sclk = spi_sclk; hi_mosi = spi_mosi;
        @(negedge tck); #1;
    endtask

    task automatic shift(input int n, input logic [63:0] din, output logic [63:0] dout,
                         output logic [63:0] oe_s, output logic [63:0] cs_h,
                         output logic [63:0] sc_h, output logic [63:0] mo_h);
        dout = '0; oe_s = '0; cs_h = '0; sc_h = '0; mo_h = '0;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo; oe_s[i] = tdo_oe;
            tick(i == n - 1, din[i]);
            cs_h[i] = hi_cs; sc_h[i] = hi_sclk; mo_h[i] = hi_mosi;
        end
    endtask

    task automatic dr_enter(); tick(1, 0); tick(0, 0); tick(0, 0); endtask
    task automatic leave();    tick(1, 0); tick(0, 0); endtask

    task automatic load_ir(input logic [5:0] code);
        logic [63:0] o, a, b, c, d;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        shift(6, {58'h0, code}, o, a, b, c, d);
        check("R2 ir capture", o[5:0], 6'b000001);
        leave();
    endtask

    task automatic read_id(input string req);
        logic [63:0] o, oe, cs, sc, mo;
        dr_enter();
        shift(32, 64'h0, o, oe, cs, sc, mo);
        check(req, o[31:0], IDV);
        check("R9 oe during id shift", oe[31:0], 32'hFFFF_FFFF);
        check("R5 cs idle during id shift", cs[31:0], 32'hFFFF_FFFF);
        check("R9 oe low after exit", {tdo_oe, tdo}, 2'b00);
        leave();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] o, oe, cs, sc, mo, din, exp;
        int base;
        tdi = 1'b1;
        repeat (2) @(negedge tck);
        #1;
        check("R9 reset oe/tdo", {tdo_oe, tdo}, 2'b00);
        check("R5 reset cs_n", spi_cs_n, 1'b1);
        check("R6 reset sclk", spi_sclk, 1'b0);
        check("R7 reset mosi", spi_mosi, 1'b0);
        trst_n = 1'b1;
        tick(0, 0);
        read_id("R3 idcode after reset");

        // Sweep every instruction code through an 8-bit DR shift.
        for (int c = 0; c < 64; c++) begin
            load_ir(c[5:0]);
            base = fl_cnt;
            din  = {56'h0, 8'h5A ^ {2'b00, c[5:0]}};
            dr_enter();
            shift(8, din, o, oe, cs, sc, mo);
            check("R9 oe sweep", oe[7:0], 8'hFF);
            if (c[5:0] == WIN) begin
                for (int i = 0; i < 8; i++) exp[i] = fl_tx[(base + i) % 64];
                check("R8 tdo follows miso", o[7:0], exp[7:0]);
                for (int i = 0; i < 8; i++) exp[i] = fl_rx[(base + i) % 64];
                check("R7 flash received tdi", exp[7:0], din[7:0]);
                check("R7 mosi while selected", mo[7:0], din[7:0]);
                check("R6 flash edge count", fl_cnt - base, 8);
                check("R6 sclk high while selected", sc[7:0], 8'hFF);
                check("R5 cs low in shift", cs[7:0], 8'h00);
            end else begin
                if (c[5:0] == IDC) check("R3 id in sweep", o[7:0], IDV[7:0]);
                else               check("R4 bypass delay", o[7:0], {din[6:0], 1'b0});
                check("R5 cs idle other code", cs[7:0], 8'hFF);
                check("R6 sclk quiet other code", sc[7:0], 8'h00);
                check("R7 mosi quiet other code", mo[7:0], 8'h00);
                check("R6 no flash edges", fl_cnt - base, 0);
            end
            check("R5 cs high after exit", spi_cs_n, 1'b1);
            leave();
        end

        // Pause-DR inside a window transfer.
        load_ir(WIN);
        base = fl_cnt;
        dr_enter();
        check("R5 cs low on entry", spi_cs_n, 1'b0);
        tick(0, 1);
        tick(1, 0);
        check("R5 cs high in exit1", spi_cs_n, 1'b1);
        tick(0, 0);
        tick(0, 0);
        check("R5 cs high in pause", hi_cs, 1'b1);
        check("R6 sclk low in pause", hi_sclk, 1'b0);
        check("R9 oe low in pause", tdo_oe, 1'b0);
        tick(1, 0);
        tick(0, 0);
        check("R5 cs low on resume", spi_cs_n, 1'b0);
        check("R8 tdo equals miso", tdo, spi_miso);
        tick(1, 0);
        check("R6 edges across pause", fl_cnt - base, 3);
        leave();

        // Five TMS-high edges from Shift-DR with bypass active.
        load_ir(6'h3F);
        dr_enter();
        tick(0, 0);
        repeat (5) tick(1, 0);
        tick(0, 0);
        read_id("R1 five ones from shift-dr");

        // Five TMS-high edges from Shift-IR.
        load_ir(6'h3F);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(0, 0);
        repeat (5) tick(1, 0);
        tick(0, 0);
        read_id("R1 five ones from shift-ir");

        // Asynchronous test reset during a window transfer.
        load_ir(WIN);
        dr_enter();
        check("R5 cs low before trst", spi_cs_n, 1'b0);
        trst_n = 1'b0;
        #1;
        check("R1 trst releases cs", {spi_cs_n, tdo_oe}, 2'b10);
        @(negedge tck); #1;
        trst_n = 1'b1;
        tick(0, 0);
        read_id("R2 trst restores idcode");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule